// File: doc/BRIEF.md
# Configurable External Interrupt Trigger Unit

This block sits between six asynchronous interrupt request lines and an interrupt controller. It turns each raw line into one clean request, and that request is either level-sensitive or edge-captured. Each line is first synchronised to the local clock. A 2-bit mode field per source then selects what makes the request active: a high level, a low level, a rising edge or a falling edge.

In the two level modes the request follows the synchronised line, inverted when the mode is active-low. In the two edge modes a qualifying transition sets a sticky pending flag, and the request reflects that flag. An interrupt handler removes the flag by writing a 1 to the source's bit in a write-only clear word. The mode fields and the clear word sit behind a small register port. Writes are synchronous. Reads are combinational, so the mode words can be read back.

The six sources are numbered 0 to 5 in this order: primary line 0, primary line 1, auxiliary line A, primary line 2, primary line 3, auxiliary line B. Index i drives rawIrq[i] and irqOut[i].

Top module: `xirq_top`

## Requirements
- R1: After reset every mode field reads 0, which selects active-high level sensing, and each output follows its raw input.
- R2: Mode word address 0 holds source 0 at bits [1:0], source 1 at [3:2], source 2 at [5:4] and source 3 at [7:6]. Mode word address 1 holds source 4 at bits [1:0] and source 5 at [3:2]. Other bits of these words are not stored and read back as 0.
- R3: In the level modes (00 active-high, 01 active-low) the output equals the raw input, inverted for 01, with no latching. A raw change shows on the output after the second rising clock edge.
- R4: In mode 10 (rising edge) or 11 (falling edge) a qualifying transition sets a pending flag. The output goes high after the third rising clock edge following the raw change. It then stays high after the input returns to its idle value.
- R5: Writing address 2 with a 1 at the source's clear bit drops that source's pending flag at that clock edge. The clear bits for sources 0 to 5 are 17, 20, 21, 22, 23 and 24.
- R6: Clear bits written as 0, and every other bit of the clear word, leave all pending flags unchanged.
- R7: A clear write leaves a source in a level mode unchanged.
- R8: If a qualifying edge is detected in the same cycle as a clear write for that source, the flag stays set.
- R9: A write that changes a source's mode field also drops that source's pending flag. A write that gives the field the value it already holds leaves the flag alone.
- R10: Reading address 2 (the clear word) or address 3 returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Write strobe for the register port |
| addr | input | ADDR_W (2) | Register address: 0 and 1 for the mode words, 2 for the clear word |
| wrData | input | DATA_W (32) | Write data |
| rdData | output | DATA_W (32) | Combinational read data for `addr` |
| rawIrq | input | 6 | Asynchronous raw request lines, one per source |
| irqOut | output | 6 | Conditioned request, one per source |

## Verification
Directed steps put a different mode in each source at the same time. The same raw pattern therefore gives a different output bit per source, which separates a wrong field decode from a wrong polarity. Edges are driven toward and away from the idle level, to tell sticky capture apart from level following. Clear writes are aimed at edge sources, at level sources and at reserved bits only, and one clear is timed to land on a fresh edge. A long seeded random run then toggles lines, rewrites modes and issues clear words at random, against a cycle model of the requirements. This reaches the interplay of mode changes, clears and edges that the directed steps do not.

// File: rtl/xirq_pkg.sv
package xirq_pkg;
  localparam int NUM_SRC        = 6;
  localparam int MODE_W         = 2;
  localparam int MODES_PER_WORD = 4;
  localparam int CLR_POS [NUM_SRC] = '{17, 20, 21, 22, 23, 24};

  typedef enum logic [MODE_W-1:0] {
    TRIG_HIGH = 2'b00,
    TRIG_LOW  = 2'b01,
    TRIG_RISE = 2'b10,
    TRIG_FALL = 2'b11
  } trigMode_e;

  typedef struct packed {
    logic [NUM_SRC-1:0] clrHit;
    logic [NUM_SRC-1:0] modeChg;
  } strobe_t;
endpackage

// File: rtl/xirq_ctrl.sv
module xirq_ctrl
  import xirq_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 2,
  parameter int MODE_ADDR = 0,
  parameter int CLR_ADDR  = 2
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           wrEn,
  input  logic [ADDR_W-1:0]              addr,
  input  logic [DATA_W-1:0]              wrData,
  output logic [DATA_W-1:0]              rdData,
  output logic [NUM_SRC-1:0][MODE_W-1:0] modeVec,
  output strobe_t                        strb
);
  logic clrSel;
  logic unusedWr;

  assign clrSel   = wrEn && (addr == ADDR_W'(CLR_ADDR));
  assign unusedWr = ^wrData;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_fld
    localparam int WORD = i / MODES_PER_WORD;
    localparam int LSB  = (i % MODES_PER_WORD) * MODE_W;
    logic              fieldWr;
    logic [MODE_W-1:0] fieldNew;
    logic [MODE_W-1:0] fieldQ;

    assign fieldWr  = wrEn && (addr == ADDR_W'(MODE_ADDR + WORD));
    assign fieldNew = wrData[LSB +: MODE_W];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)        fieldQ <= TRIG_HIGH;
      else if (fieldWr) fieldQ <= fieldNew;
    end

    assign modeVec[i]      = fieldQ;
    assign strb.modeChg[i] = fieldWr && (fieldNew != fieldQ);
    assign strb.clrHit[i]  = clrSel && wrData[CLR_POS[i]];
  end

  always_comb begin
    rdData = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (addr == ADDR_W'(MODE_ADDR + i / MODES_PER_WORD))
        rdData[(i % MODES_PER_WORD) * MODE_W +: MODE_W] = modeVec[i];
    end
  end
endmodule

// File: rtl/xirq_datapath.sv
module xirq_datapath
  import xirq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic [NUM_SRC-1:0]             rawIrq,
  input  logic [NUM_SRC-1:0][MODE_W-1:0] modeVec,
  input  strobe_t                        strb,
  output logic [NUM_SRC-1:0]             edgeHit,
  output logic [NUM_SRC-1:0]             irqOut
);
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    logic [SYNC_STAGES-1:0] syncQ;
    logic                   prevQ;
    logic                   pendQ;
    logic                   lineNow;
    logic                   isEdge;
    logic                   activeLow;

    assign lineNow   = syncQ[SYNC_STAGES-1];
    assign isEdge    = modeVec[i][1];
    assign activeLow = modeVec[i][0];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        syncQ <= '0;
        prevQ <= 1'b0;
      end else begin
        syncQ <= {syncQ[SYNC_STAGES-2:0], rawIrq[i]};
        prevQ <= lineNow;
      end
    end

    assign edgeHit[i] = isEdge && (activeLow ? (prevQ && !lineNow) : (!prevQ && lineNow));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                 pendQ <= 1'b0;
      else if (strb.modeChg[i])  pendQ <= 1'b0;
      else if (edgeHit[i])       pendQ <= 1'b1;
      else if (strb.clrHit[i])   pendQ <= 1'b0;
    end

    assign irqOut[i] = isEdge ? pendQ : (lineNow ^ activeLow);
  end
endmodule

// File: rtl/xirq_top.sv
module xirq_top
  import xirq_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int ADDR_W      = 2,
  parameter int SYNC_STAGES = 2,
  parameter int MODE_ADDR   = 0,
  parameter int CLR_ADDR    = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [DATA_W-1:0]  wrData,
  output logic [DATA_W-1:0]  rdData,
  input  logic [NUM_SRC-1:0] rawIrq,
  output logic [NUM_SRC-1:0] irqOut
);
  logic [NUM_SRC-1:0][MODE_W-1:0] modeVec;
  strobe_t                        strb;
  logic [NUM_SRC-1:0]             edgeHit;

  xirq_ctrl #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .MODE_ADDR(MODE_ADDR), .CLR_ADDR(CLR_ADDR)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .modeVec(modeVec), .strb(strb)
  );

  xirq_datapath #(
    .SYNC_STAGES(SYNC_STAGES)
  ) dp_i (
    .clk(clk), .rstN(rstN), .rawIrq(rawIrq), .modeVec(modeVec), .strb(strb),
    .edgeHit(edgeHit), .irqOut(irqOut)
  );
endmodule

// File: rtl/xirq_chk.sv
module xirq_chk
  import xirq_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 2,
  parameter int CLR_ADDR = 2
) (
  input logic                           clk,
  input logic                           rstN,
  input logic                           wrEn,
  input logic [ADDR_W-1:0]              addr,
  input logic [DATA_W-1:0]              wrData,
  input logic [DATA_W-1:0]              rdData,
  input logic [NUM_SRC-1:0]             irqOut,
  input logic [NUM_SRC-1:0][MODE_W-1:0] modeVec,
  input strobe_t                        strb,
  input logic [NUM_SRC-1:0]             edgeHit
);
  // R10
  clr_read_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (addr == ADDR_W'(CLR_ADDR)) |-> (rdData == '0));

  // R6
  idle_no_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |-> (strb == '0));

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_chk
    // R4
    pend_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
      (modeVec[i][1] && irqOut[i] && !strb.clrHit[i] && !strb.modeChg[i]) |=> irqOut[i]);

    // R5
    clr_drops_chk: assert property (@(posedge clk) disable iff (!rstN)
      (modeVec[i][1] && strb.clrHit[i] && !edgeHit[i] && !strb.modeChg[i]) |=> !irqOut[i]);

    // R8
    edge_beats_clr_chk: assert property (@(posedge clk) disable iff (!rstN)
      (modeVec[i][1] && strb.clrHit[i] && edgeHit[i] && !strb.modeChg[i]) |=> irqOut[i]);

    // R9
    mode_change_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
      strb.modeChg[i] |=> (!modeVec[i][1] || !irqOut[i]));

    // R6
    zero_bit_no_clr_chk: assert property (@(posedge clk) disable iff (!rstN)
      (wrEn && addr == ADDR_W'(CLR_ADDR) && !wrData[CLR_POS[i]]) |-> !strb.clrHit[i]);
  end
endmodule

bind xirq_top xirq_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .CLR_ADDR(CLR_ADDR)
) chk_i (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
  .rdData(rdData), .irqOut(irqOut), .modeVec(modeVec), .strb(strb), .edgeHit(edgeHit)
);

// File: tb/xirq_top_tb_top.sv
module xirq_top_tb_top;
  localparam int NSRC = 6;
  localparam int CLRB [NSRC] = '{17, 20, 21, 22, 23, 24};

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [1:0]  addr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic [5:0]  rawIrq = '0;
  logic [5:0]  irqOut;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #4 clk = ~clk;

  xirq_top dut_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .rawIrq(rawIrq), .irqOut(irqOut)
  );

  // cycle model built from the requirements
  logic [5:0]      mS1, mS2, mPrev, mPend;
  logic [5:0][1:0] mMode;

  always @(posedge clk) begin
    if (!rstN) begin
      mS1 = '0; mS2 = '0; mPrev = '0; mPend = '0; mMode = '0;
    end else begin
      logic [5:0]      nPend;
      logic [5:0][1:0] nMode;
      for (int i = 0; i < NSRC; i++) begin
        logic ed;
        logic clr;
        logic [1:0] nf;
        ed = mMode[i][1] && (mMode[i][0] ? (mPrev[i] && !mS2[i]) : (!mPrev[i] && mS2[i]));
        clr = wrEn && addr == 2'd2 && wrData[CLRB[i]];
        nf = mMode[i];
        if (wrEn && addr == ((i < 4) ? 2'd0 : 2'd1)) nf = wrData[(i % 4) * 2 +: 2];
        if (nf != mMode[i]) nPend[i] = 1'b0;
        else if (ed)        nPend[i] = 1'b1;
        else if (clr)       nPend[i] = 1'b0;
        else                nPend[i] = mPend[i];
        nMode[i] = nf;
      end
      mPend = nPend; mPrev = mS2; mS2 = mS1; mS1 = rawIrq; mMode = nMode;
    end
  end

  function automatic logic [5:0] expOut();
    logic [5:0] r;
    for (int i = 0; i < NSRC; i++) r[i] = mMode[i][1] ? mPend[i] : (mS2[i] ^ mMode[i][0]);
    return r;
  endfunction

  function automatic logic [31:0] expRd(logic [1:0] a);
    logic [31:0] r = '0;
    if (a == 2'd0) r[7:0] = {mMode[3], mMode[2], mMode[1], mMode[0]};
    else if (a == 2'd1) r[3:0] = {mMode[5], mMode[4]};
    return r;
  endfunction

  task automatic report();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(int n = 1);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d);
    wrEn = 1'b1; addr = a; wrData = d;
    tick();
    wrEn = 1'b0; wrData = '0;
  endtask

  task automatic rd(string req, logic [1:0] a, logic [31:0] exp);
    addr = a;
    #1;
    check(req, rdData, exp);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected<=100000", cyc);
      report();
      $finish;
    end
  end

  initial begin
    tick(3);
    rstN = 1'b1;
    tick();
    // R1 reset state
    rd("R1", 2'd0, 32'h0);
    rd("R1", 2'd1, 32'h0);
    check("R1", irqOut, 6'b000000);

    // R3 latency of two edges, active-high default (R1)
    rawIrq = 6'b101010;
    tick();
    check("R3", irqOut, 6'b000000);
    tick();
    check("R1", irqOut, 6'b101010);
    rawIrq = 6'b000000;
    tick(4);
    check("R3", irqOut, 6'b000000);

    // R2 field layout and readback
    wr(2'd0, 32'h0000_00E4);
    wr(2'd1, 32'hFFFF_FFF6);
    rd("R2", 2'd0, 32'h0000_00E4);
    rd("R2", 2'd1, 32'h0000_0006);
    check("R3", irqOut, 6'b100010);

    // R4 rising capture on sources 2 and 4
    rawIrq = 6'b010100;
    tick(2);
    check("R4", irqOut, 6'b100010);
    tick();
    check("R4", irqOut, 6'b110110);
    rawIrq = 6'b000000;
    tick(4);
    check("R4", irqOut, 6'b110110);
    // R4 falling capture on source 3
    rawIrq = 6'b001000;
    tick(4);
    check("R4", irqOut, 6'b110110);
    rawIrq = 6'b000000;
    tick(4);
    check("R4", irqOut, 6'b111110);

    // R6 reserved bits and zero bits
    wr(2'd2, ~32'h01F2_0000);
    wr(2'd2, 32'h0);
    check("R6", irqOut, 6'b111110);

    // R5 clear source 2
    wr(2'd2, 32'h1 << 21);
    check("R5", irqOut, 6'b111010);

    // R7 clears aimed at level sources 0, 1, 5
    wr(2'd2, (32'h1 << 17) | (32'h1 << 20) | (32'h1 << 24));
    check("R7", irqOut, 6'b111010);

    // R8 fresh rising edge on source 4 coincides with its clear
    rawIrq = 6'b010000;
    tick(2);
    wr(2'd2, 32'h1 << 23);
    check("R8", irqOut, 6'b111010);
    wr(2'd2, 32'h1 << 23);
    check("R5", irqOut, 6'b101010);

    // R9 same value keeps, new value drops
    wr(2'd0, 32'h0000_00E4);
    check("R9", irqOut, 6'b101010);
    wr(2'd0, 32'h0000_00A4);
    check("R9", irqOut, 6'b100010);
    rd("R2", 2'd0, 32'h0000_00A4);

    // R10 clear word and spare address read as zero
    rd("R10", 2'd2, 32'h0);
    rd("R10", 2'd3, 32'h0);

    // random phase against the model
    void'($urandom(32'd20240607));
    for (int n = 0; n < 3000; n++) begin
      tick();
      check("R3/R4/R5/R8/R9 random", irqOut, expOut());
      check("R2/R10 random", rdData, expRd(addr));
      rawIrq = rawIrq ^ (6'($urandom) & 6'($urandom) & 6'($urandom));
      wrEn   = ($urandom % 6) == 0;
      addr   = 2'($urandom);
      wrData = $urandom;
      #1;
    end
    wrEn = 1'b0;
    tick();
    report();
    $finish;
  end
endmodule